// File: doc/BRIEF.md
# Bit-Serial Opcode-Snooping Register Memory

This block is a bank of 56-bit storage registers attached to a bit-serial processor bus that offers no address pins and no read or write strobe. All of its control comes from watching the serial instruction line. A machine cycle is 56 bit-clock periods long. Near the end of each cycle a sync strobe is raised while the fetched instruction travels over the instruction line one bit per clock. The block shifts that instruction in and decodes it when the strobe falls.

If the instruction is a memory-write opcode, the block samples the shared data line in each of the 56 periods of the following machine cycle and stores the word in the register that the instruction selects. If it is a memory-read opcode, the block drives the selected register onto the data line during the following machine cycle, one bit per period, with its output enable asserted for exactly that cycle. Any other opcode is ignored. The bidirectional data line is modelled as separate input, output and output-enable signals.

A modulo-56 bit counter keeps track of the position in the machine cycle. Each falling edge of the sync strobe sets it back into step with the bus. When a cycle has no strobe, the counter keeps running on its own, and an operation decoded earlier still runs in its scheduled cycle.

Top module: `snoopram_top`

## Requirements
- R1: A machine cycle is 56 bit periods. The first period in which `sync_i` is low after a period in which it was high is bit 0 of the next machine cycle, whatever the internal counter held before. Without a strobe, the counter wraps every 56 periods.
- R2: While `sync_i` is low, `insn_i` is ignored. Address bits sent in the early part of a cycle never affect decoding, even when they look like a memory opcode.
- R3: While `sync_i` is high, one instruction bit is taken from `insn_i` per period, least significant bit first. The last 10 bits taken before the strobe falls form the instruction. Bits [9:4] are the opcode: 6'b101110 means read and 6'b101100 means write (the default parameter values). Bits [3:0] select one of 16 registers.
- R4: After a write opcode, `dat_i` is sampled in periods 0 to 55 of the next machine cycle. Period k supplies bit k of the selected register.
- R5: After a read opcode, `dat_oe` is high in exactly the 56 periods of the next machine cycle, and in period k `dat_o` carries bit k of the selected register.
- R6: After any other opcode, or in a cycle with no pending operation, `dat_oe` and `dat_o` stay low and no register changes.
- R7: When a cycle carries no strobe, nothing new is decoded. An operation decoded in the cycle before still completes, and the cycle after it is idle.
- R8: While reset is asserted and right after it, `dat_oe` is low and no operation is pending.
- R9: A write changes only the selected register. The other 15 keep their contents.
- R10: An instruction can be decoded in the same cycle in which an earlier operation is running, so read and write cycles can follow one another back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one data bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Instruction strobe; high while the instruction is on `insn_i` |
| insn_i | input | 1 | Serial instruction/address line |
| dat_i | input | 1 | Data line as seen by the block |
| dat_o | output | 1 | Data bit driven by the block during a read cycle |
| dat_oe | output | 1 | High while the block drives the data line |

## Verification
The hardest situations to reach from the ports are a bus whose cycle phase has drifted, and a pending operation that must finish in a cycle with no strobe. The stimulus inserts runs of stray idle bits whose count is not a multiple of 56, so the internal counter drifts out of phase, and then checks that the next strobe fall brings reads and writes back into alignment. It also follows decoded reads and writes with cycles that carry no strobe. Address-phase bits shaped like read opcodes are placed ahead of a harmless instruction to show that they are ignored. Constrained-random cycles then mix reads, writes, other opcodes and missing strobes against a register model kept in the bench.

// File: rtl/snoopram_pkg.sv
package snoopram_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } mem_op_e;
endpackage

// File: rtl/snoopram_timer.sv
module snoopram_timer #(
  parameter int unsigned WORD_W = 56,
  parameter int unsigned CNT_W  = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync,
  output logic             start,
  output logic             last_bit,
  output logic [CNT_W-1:0] bit_idx
);
  logic             sync_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             at_end;

  always_comb begin
    start   = sync_q & ~sync;
    at_end  = (cnt_q == CNT_W'(WORD_W - 1));
    if (start)       cnt_d = CNT_W'(1);
    else if (at_end) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
    bit_idx  = start ? '0 : cnt_q;
    last_bit = ~start & at_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sync_q <= sync;
      cnt_q  <= cnt_d;
    end
  end

  // R1: a strobe fall realigns the counter to bit 1 of the new cycle
  assert_realign_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt_q == CNT_W'(1)));

  // R1: the counter never leaves the 56-period range
  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(WORD_W));
endmodule

// File: rtl/snoopram_snoop.sv
module snoopram_snoop
  import snoopram_pkg::*;
#(
  parameter int unsigned         INSN_W = 10,
  parameter int unsigned         SEL_W  = 4,
  parameter int unsigned         OPC_W  = INSN_W - SEL_W,
  parameter logic [OPC_W-1:0]    RD_OPC = 6'b101110,
  parameter logic [OPC_W-1:0]    WR_OPC = 6'b101100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync,
  input  logic             insn,
  output mem_op_e          dec_op,
  output logic [SEL_W-1:0] dec_sel
);
  logic [INSN_W-1:0] shreg;
  logic [INSN_W-1:0] shreg_d;
  logic [OPC_W-1:0]  opc;

  always_comb begin
    shreg_d = {insn, shreg[INSN_W-1:1]};
    opc     = shreg[INSN_W-1:SEL_W];
    dec_sel = shreg[SEL_W-1:0];
    if (opc == RD_OPC)      dec_op = OP_RD;
    else if (opc == WR_OPC) dec_op = OP_WR;
    else                    dec_op = OP_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    shreg <= '0;
    else if (sync) shreg <= shreg_d;
  end

  // R2: instruction line ignored while the strobe is low
  assert_addr_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sync |=> $stable(shreg));
endmodule

// File: rtl/snoopram_bank.sv
module snoopram_bank #(
  parameter int unsigned WORD_W = 56,
  parameter int unsigned NREGS  = 16,
  parameter int unsigned SEL_W  = $clog2(NREGS),
  parameter int unsigned CNT_W  = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] sel,
  input  logic [CNT_W-1:0] bit_idx,
  input  logic             wr_bit,
  output logic             rd_bit
);
  logic [WORD_W-1:0] mem [NREGS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[sel][bit_idx] <= wr_bit;
  end

  always_comb rd_bit = mem[sel][bit_idx];
endmodule

// File: rtl/snoopram_top.sv
module snoopram_top
  import snoopram_pkg::*;
#(
  parameter int unsigned WORD_W  = 56,
  parameter int unsigned INSN_W  = 10,
  parameter int unsigned NREGS   = 16,
  parameter int unsigned RD_CODE = 'h2E,
  parameter int unsigned WR_CODE = 'h2C
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  input  logic insn_i,
  input  logic dat_i,
  output logic dat_o,
  output logic dat_oe
);
  localparam int unsigned SEL_W = $clog2(NREGS);
  localparam int unsigned OPC_W = INSN_W - SEL_W;
  localparam int unsigned CNT_W = $clog2(WORD_W);

  logic             rst_meta, rst_n_s;
  logic             start, last_bit, wr_en, rd_bit;
  logic [CNT_W-1:0] bit_idx;
  mem_op_e          dec_op, op_q, op_d, cur_op;
  logic [SEL_W-1:0] dec_sel, sel_q, sel_d, cur_sel;

  // reset: asserted asynchronously, released through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  snoopram_timer #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n_s), .sync(sync_i),
    .start(start), .last_bit(last_bit), .bit_idx(bit_idx)
  );

  snoopram_snoop #(
    .INSN_W(INSN_W), .SEL_W(SEL_W), .OPC_W(OPC_W),
    .RD_OPC(OPC_W'(RD_CODE)), .WR_OPC(OPC_W'(WR_CODE))
  ) u_snoop (
    .clk(clk), .rst_n(rst_n_s), .sync(sync_i), .insn(insn_i),
    .dec_op(dec_op), .dec_sel(dec_sel)
  );

  snoopram_bank #(.WORD_W(WORD_W), .NREGS(NREGS), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_bank (
    .clk(clk), .wr_en(wr_en), .sel(cur_sel), .bit_idx(bit_idx),
    .wr_bit(dat_i), .rd_bit(rd_bit)
  );

  // the operation of the running cycle: fresh decode in bit 0, held afterwards
  always_comb begin
    cur_op  = start ? dec_op  : op_q;
    cur_sel = start ? dec_sel : sel_q;
    op_d    = last_bit ? OP_NONE : cur_op;
    sel_d   = cur_sel;
    wr_en   = (cur_op == OP_WR);
    dat_oe  = (cur_op == OP_RD);
    dat_o   = dat_oe & rd_bit;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      op_q  <= OP_NONE;
      sel_q <= '0;
    end else begin
      op_q  <= op_d;
      sel_q <= sel_d;
    end
  end

  // R5: driving begins only at a cycle boundary
  assert_oe_rise_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(dat_oe) |-> start);

  // R5: driving stops only after the last bit period or at a realignment
  assert_oe_fall_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(dat_oe) |-> (start || $past(last_bit)));

  // R4: never drives the line while capturing from it
  assert_no_drive_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(dat_oe && wr_en));

  // R8: no drive while reset is held
  always_comb begin
    if (!rst_n_s) assert_quiet_in_reset_R8: assert (!dat_oe);
  end
endmodule

// File: tb/tb_snoopram_top.sv
module tb_snoopram_top;
  localparam logic [5:0] RD_OPC = 6'b101110;
  localparam logic [5:0] WR_OPC = 6'b101100;

  logic clk = 1'b0;
  logic rst_n, sync_i, insn_i, dat_i, dat_o, dat_oe;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [55:0] model [16];
  int pend_op;   // 0 none, 1 read, 2 write
  int pend_sel;

  always #10 clk = ~clk;

  snoopram_top dut (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .insn_i(insn_i),
    .dat_i(dat_i), .dat_o(dat_o), .dat_oe(dat_oe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int dec_op(input logic [9:0] i);
    if (i[9:4] == RD_OPC) return 1;
    if (i[9:4] == WR_OPC) return 2;
    return 0;
  endfunction

  function automatic logic [9:0] mk(input logic [5:0] opc, input int sel);
    return {opc, 4'(sel)};
  endfunction

  function automatic logic [55:0] rnd56();
    return {24'($urandom), $urandom};
  endfunction

  // one 56-bit machine cycle; instruction sent in bits 46..55 when with_sync
  task automatic run_cycle(input logic [9:0] insn, input bit with_sync,
                           input logic [55:0] wdata, input logic [45:0] addr,
                           input string tag);
    logic [55:0] got, oe_seen, exp_oe;
    for (int b = 0; b < 56; b++) begin
      @(negedge clk);
      sync_i = with_sync && (b >= 46);
      insn_i = (b >= 46) ? insn[b-46] : addr[b];
      dat_i  = wdata[b];
      #5;
      got[b]     = dat_o;
      oe_seen[b] = dat_oe;
    end
    exp_oe = (pend_op == 1) ? {56{1'b1}} : 56'd0;
    chk(oe_seen == exp_oe, (pend_op == 1) ? "R5" : "R6", {tag, " oe"}, 64'(oe_seen), 64'(exp_oe));
    if (pend_op == 1)
      chk(got == model[pend_sel], "R5", {tag, " read data"}, 64'(got), 64'(model[pend_sel]));
    else
      chk(got == 56'd0, "R6", {tag, " idle data"}, 64'(got), 64'd0);
    if (pend_op == 2) model[pend_sel] = wdata;
    if (with_sync) begin
      pend_op  = dec_op(insn);
      pend_sel = int'(insn[3:0]);
    end else begin
      pend_op = 0;
    end
  endtask

  task automatic idle_bits(input int n);
    bit any_oe = 1'b0;
    for (int b = 0; b < n; b++) begin
      @(negedge clk);
      sync_i = 1'b0;
      insn_i = 1'($urandom);
      dat_i  = 1'($urandom);
      #5;
      any_oe |= dat_oe;
    end
    chk(!any_oe, "R1", "no drive in stray bits", 64'(any_oe), 64'd0);
  endtask

  task automatic read_back(input int sel, input string tag);
    run_cycle(mk(RD_OPC, sel), 1'b1, rnd56(), 46'($urandom), tag);
    run_cycle(mk(6'h00, 0), 1'b1, rnd56(), 46'($urandom), tag);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    pend_op = 0; pend_sel = 0;
    for (int i = 0; i < 16; i++) model[i] = 56'd0;
    rst_n = 1'b0; sync_i = 1'b0; insn_i = 1'b0; dat_i = 1'b0;
    repeat (4) @(negedge clk);
    #5;
    chk(dat_oe == 1'b0, "R8", "oe in reset", 64'(dat_oe), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #5;
    chk(dat_oe == 1'b0, "R8", "oe after reset", 64'(dat_oe), 64'd0);

    // fill every register so later reads have defined model values (R4, R10)
    run_cycle(mk(WR_OPC, 0), 1'b1, rnd56(), 46'($urandom), "R8 first");
    for (int i = 0; i < 16; i++)
      run_cycle(mk(WR_OPC, (i + 1) % 16), i < 15, rnd56(), 46'($urandom), "R4 fill");
    // the last write decoded above is dropped: its cycle had no strobe (R7)
    run_cycle(mk(6'h00, 0), 1'b1, rnd56(), 46'($urandom), "R7 idle");

    // back-to-back write then read of neighbours (R9, R10)
    run_cycle(mk(WR_OPC, 5), 1'b1, rnd56(), 46'($urandom), "R10");
    run_cycle(mk(RD_OPC, 4), 1'b1, {56{1'b1}}, 46'($urandom), "R9 write 5");
    run_cycle(mk(RD_OPC, 6), 1'b1, rnd56(), 46'($urandom), "R9 neighbour 4");
    run_cycle(mk(RD_OPC, 5), 1'b1, rnd56(), 46'($urandom), "R9 neighbour 6");
    run_cycle(mk(6'h3F, 5), 1'b1, rnd56(), 46'($urandom), "R4 all ones");

    // read-shaped address bits ahead of a harmless opcode (R2, R3)
    run_cycle(mk(6'h15, 7), 1'b1, rnd56(), {4'd0, {4{mk(RD_OPC, 7)}}, 2'b0}, "R2 setup");
    run_cycle(mk(6'h00, 0), 1'b1, rnd56(), 46'($urandom), "R2 addr ignored");

    // bit order check with a single set bit (R3, R4, R5)
    run_cycle(mk(WR_OPC, 9), 1'b1, rnd56(), 46'($urandom), "R3");
    run_cycle(mk(RD_OPC, 9), 1'b1, 56'd1, 46'($urandom), "R4 lsb write");
    run_cycle(mk(6'h00, 0), 1'b1, rnd56(), 46'($urandom), "R5 lsb read");

    // missing strobe: pending read and write still complete (R7)
    run_cycle(mk(RD_OPC, 9), 1'b1, rnd56(), 46'($urandom), "R7 setup");
    run_cycle(mk(RD_OPC, 2), 1'b0, rnd56(), 46'($urandom), "R7 read completes");
    run_cycle(mk(WR_OPC, 2), 1'b0, rnd56(), 46'($urandom), "R7 idle after");
    run_cycle(mk(WR_OPC, 11), 1'b1, rnd56(), 46'($urandom), "R7 setup w");
    run_cycle(mk(RD_OPC, 11), 1'b0, rnd56(), 46'($urandom), "R7 write completes");
    read_back(11, "R7 verify");

    // drift the counter, then let a strobe fall realign it (R1)
    idle_bits(23);
    run_cycle(mk(6'h00, 0), 1'b0, rnd56(), 46'($urandom), "R1 drifted");
    run_cycle(mk(WR_OPC, 14), 1'b1, rnd56(), 46'($urandom), "R1 realign");
    run_cycle(mk(RD_OPC, 14), 1'b1, rnd56(), 46'($urandom), "R1 aligned write");
    run_cycle(mk(6'h00, 0), 1'b1, rnd56(), 46'($urandom), "R1 aligned read");
    idle_bits(37);
    read_back(3, "R1 second drift");

    // constrained random mix
    for (int n = 0; n < 250; n++) begin
      int kind = int'($urandom % 4);
      int sel  = int'($urandom % 16);
      logic [5:0] opc;
      if (kind == 0)      opc = RD_OPC;
      else if (kind == 1) opc = WR_OPC;
      else begin
        opc = 6'($urandom);
        if (opc == RD_OPC || opc == WR_OPC) opc = 6'h01;
      end
      run_cycle(mk(opc, sel), kind != 3, rnd56(), 46'($urandom), "R10 random");
    end
    run_cycle(mk(6'h00, 0), 1'b1, rnd56(), 46'($urandom), "R6 flush");
    run_cycle(mk(6'h00, 0), 1'b1, rnd56(), 46'($urandom), "R6 flush");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(64'd20 * 64'd200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule